// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block turns the pin levels of one GPIO bank into interrupt requests. The bank is split into ports of eight pins. Each pin has a trigger setting that makes it sensitive to a rising edge, a falling edge, either edge, a high level or a low level. A matching event sets the pin's pending bit. Software reads the pending bits, masks them per pin and clears edge events by writing ones. Pin inputs are expected to be synchronized to `clk` before they reach the block.

Configuration uses a simple write-strobe register bus with a combinational read port. Each register kind occupies a 16-byte group, and the ports follow one another at a 4-byte stride inside it. Two masked aliases change only the pins whose select bit is set, so two agents can program different pins without a read-modify-write. Each port raises its own request line. The bank line is the OR of all ports.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset, every enable bit reads 0, and `port_irq` and `bank_irq` are low from the first cycle after reset until software sets an enable bit.
- R2: A pin whose trigger bits (both-lane, edge-lane, polarity-lane) are 0/1/1 sets its pending bit on a 0-to-1 transition, seen one clock after the input changes. It ignores 1-to-0 transitions.
- R3: With trigger bits 0/1/0 a pin sets its pending bit on a 1-to-0 transition and ignores 0-to-1 transitions.
- R4: With trigger bits 1/1/0 a pin sets its pending bit on a transition in either direction.
- R5: With trigger bits 0/0/1 the pending bit equals the pin level of the previous cycle, so it drops when the pin goes low.
- R6: With trigger bits 0/0/0 the pending bit equals the inverted pin level of the previous cycle. This is also the reset trigger setting.
- R7: Writing to the clear word at 0x70 + 4*port clears edge-mode pending bit p when data bit p is 1 and leaves it alone when bit p is 0. On a level-mode pin whose level is still active, the clear has no lasting effect.
- R8: When a new edge and a clear hit the same pin in the same cycle, the pending bit ends up set.
- R9: An edge that arrives after a pin's pending bit has been cleared sets the bit again.
- R10: `port_irq[k]` is high when any pin of port k has both its pending bit and its enable bit set. `bank_irq` is high when any `port_irq` bit is high.
- R11: A write to the masked enable alias at 0x850 + 4*port updates enable bit p to data bit p only where data bit 8+p is 1. All other enable bits keep their value.
- R12: A write to the masked trigger alias at 0x860 + 4*port updates pin p's three trigger bits only where data bit 24+p is 1. The new bits are taken from data bits p (polarity), 8+p (edge) and 16+p (both).
- R13: Reads return pending bits at 0x40 + 4*port, enable bits at 0x50 + 4*port, and the trigger word at 0x60 + 4*port, laid out as polarity in [7:0], edge in [15:8] and both in [23:16]. The clear word and the alias addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPORTS*NPINS | Synchronized pin levels; pin p of port k at bit k*NPINS+p |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| port_irq | output | NPORTS | Per-port interrupt request |
| bank_irq | output | 1 | OR of all port requests |

## Verification
The bench builds the default configuration: four ports of eight pins, a 12-bit address and a 32-bit data word. This exposes every trigger setting, both masked aliases and the 4-byte port stride. Most sequences run on port 0. A closing sequence on port 2 checks that one port's pending pin reaches `bank_irq` through the correct `port_irq` bit while the other ports stay quiet. The stimulus also reaches several corner cases:
- a clear and a fresh edge landing in the same cycle;
- an edge arriving right after a clear;
- a clear on an active level-mode pin;
- the level-low pending bits that appear right after reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register groups; the port index selects a 4-byte slot inside a group.
    localparam logic [11:0] GRP_PENDING   = 12'h040;
    localparam logic [11:0] GRP_ENABLE    = 12'h050;
    localparam logic [11:0] GRP_TRIGGER   = 12'h060;
    localparam logic [11:0] GRP_CLEAR     = 12'h070;
    localparam logic [11:0] GRP_ENA_MASKD = 12'h850;
    localparam logic [11:0] GRP_TRG_MASKD = 12'h860;

    typedef enum logic [2:0] {
        TRIG_LEVEL_LOW,
        TRIG_LEVEL_HIGH,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH
    } trig_mode_e;

    // Per-pin trigger setting as stored (three byte lanes on the bus).
    typedef struct packed {
        logic both;
        logic edge_sel;
        logic polarity;
    } pin_trig_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PENDING,
        SEL_ENABLE,
        SEL_TRIGGER,
        SEL_CLEAR,
        SEL_ENA_MASKD,
        SEL_TRG_MASKD
    } reg_sel_e;

    function automatic trig_mode_e decode_trig(pin_trig_t t);
        trig_mode_e m;
        if (!t.edge_sel)
            m = t.polarity ? TRIG_LEVEL_HIGH : TRIG_LEVEL_LOW;
        else if (t.both)
            m = TRIG_BOTH;
        else
            m = t.polarity ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

    function automatic logic is_edge_mode(trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

    function automatic logic edge_seen(trig_mode_e m, logic cur, logic last);
        logic hit;
        case (m)
            TRIG_RISE: hit = cur & ~last;
            TRIG_FALL: hit = ~cur & last;
            TRIG_BOTH: hit = cur ^ last;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic level_seen(trig_mode_e m, logic cur);
        logic act;
        case (m)
            TRIG_LEVEL_HIGH: act = cur;
            TRIG_LEVEL_LOW:  act = ~cur;
            default:         act = 1'b0;
        endcase
        return act;
    endfunction

    function automatic reg_sel_e decode_group(logic [11:0] grp);
        reg_sel_e s;
        case (grp)
            GRP_PENDING:   s = SEL_PENDING;
            GRP_ENABLE:    s = SEL_ENABLE;
            GRP_TRIGGER:   s = SEL_TRIGGER;
            GRP_CLEAR:     s = SEL_CLEAR;
            GRP_ENA_MASKD: s = SEL_ENA_MASKD;
            GRP_TRG_MASKD: s = SEL_TRG_MASKD;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_addr_dec.sv
module gpio_irq_addr_dec
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 12,
    parameter int PORT_W = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic [PORT_W-1:0] port_idx
);

    logic [11:0] grp;
    logic        upper_ok;

    if (ADDR_W > 12) begin : g_upper
        assign upper_ok = ~|bus_addr[ADDR_W-1:12];
    end else begin : g_exact
        assign upper_ok = 1'b1;
    end

    always_comb begin
        grp                = bus_addr[11:0];
        grp[2 +: PORT_W]   = '0;
        port_idx           = bus_addr[2 +: PORT_W];
        sel                = SEL_NONE;
        if (upper_ok && (int'(port_idx) < NPORTS))
            sel = decode_group(grp);
    end

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NPINS  = 8,
    parameter int DATA_W = 32,
    parameter int PORT_W = 2,
    localparam int NBITS = NPORTS * NPINS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_we,
    input  reg_sel_e                sel,
    input  logic [PORT_W-1:0]       port_idx,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [NBITS-1:0]        status_all,
    output logic [NBITS-1:0]        enable_all,
    output pin_trig_t [NBITS-1:0]   trig_all,
    output logic [NBITS-1:0]        clr_all,
    output logic [DATA_W-1:0]       bus_rdata
);

    localparam int TMASK_LSB = DATA_W - NPINS;

    // Trigger bits for each pin as carried on the write data lanes.
    pin_trig_t [NPINS-1:0] wr_trig;
    for (genvar p = 0; p < NPINS; p++) begin : g_lane
        assign wr_trig[p] = {bus_wdata[2*NPINS + p], bus_wdata[NPINS + p], bus_wdata[p]};
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic                  wr_here;
        logic [NPINS-1:0]      en_q;
        pin_trig_t [NPINS-1:0] trig_q;

        assign wr_here = bus_we && (port_idx == PORT_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q   <= '0;
                trig_q <= '0;
            end else if (wr_here) begin
                case (sel)
                    SEL_ENABLE:    en_q <= bus_wdata[NPINS-1:0];
                    SEL_ENA_MASKD: en_q <= (en_q & ~bus_wdata[NPINS +: NPINS])
                                         | (bus_wdata[NPINS-1:0] & bus_wdata[NPINS +: NPINS]);
                    SEL_TRIGGER:   trig_q <= wr_trig;
                    SEL_TRG_MASKD: begin
                        for (int p = 0; p < NPINS; p++) begin
                            if (bus_wdata[TMASK_LSB + p])
                                trig_q[p] <= wr_trig[p];
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign clr_all[g*NPINS +: NPINS]    = (wr_here && sel == SEL_CLEAR) ? bus_wdata[NPINS-1:0] : '0;
        assign enable_all[g*NPINS +: NPINS] = en_q;
        assign trig_all[g*NPINS +: NPINS]   = trig_q;
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NPORTS; g++) begin
            if (port_idx == PORT_W'(g)) begin
                case (sel)
                    SEL_PENDING: bus_rdata[NPINS-1:0] = status_all[g*NPINS +: NPINS];
                    SEL_ENABLE:  bus_rdata[NPINS-1:0] = enable_all[g*NPINS +: NPINS];
                    SEL_TRIGGER: begin
                        for (int p = 0; p < NPINS; p++) begin
                            bus_rdata[p]           = trig_all[g*NPINS + p].polarity;
                            bus_rdata[NPINS + p]   = trig_all[g*NPINS + p].edge_sel;
                            bus_rdata[2*NPINS + p] = trig_all[g*NPINS + p].both;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPINS-1:0]      pins,
    input  pin_trig_t [NPINS-1:0] trig,
    input  logic [NPINS-1:0]      clr,
    input  logic [NPINS-1:0]      enable,
    output logic [NPINS-1:0]      status,
    output logic                  irq
);

    logic [NPINS-1:0] last_q;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] status_nxt;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_mode_e mode;
        assign mode = decode_trig(trig[p]);

        always_comb begin
            if (is_edge_mode(mode))
                // a new edge outranks a clear in the same cycle
                status_nxt[p] = edge_seen(mode, pins[p], last_q[p])
                              | (status_q[p] & ~clr[p]);
            else
                status_nxt[p] = level_seen(mode, pins[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= '0;
            status_q <= '0;
        end else begin
            last_q   <= pins;
            status_q <= status_nxt;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & enable);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORTS*NPINS-1:0]   pin_in,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NPORTS-1:0]         port_irq,
    output logic                      bank_irq
);

    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int NBITS  = NPORTS * NPINS;

    reg_sel_e              sel;
    logic [PORT_W-1:0]     port_idx;
    logic [NBITS-1:0]      status_all;
    logic [NBITS-1:0]      enable_all;
    pin_trig_t [NBITS-1:0] trig_all;
    logic [NBITS-1:0]      clr_all;

    gpio_irq_addr_dec #(
        .NPORTS (NPORTS),
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W)
    ) u_dec (
        .bus_addr (bus_addr),
        .sel      (sel),
        .port_idx (port_idx)
    );

    gpio_irq_cfg #(
        .NPORTS (NPORTS),
        .NPINS  (NPINS),
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .sel        (sel),
        .port_idx   (port_idx),
        .bus_wdata  (bus_wdata),
        .status_all (status_all),
        .enable_all (enable_all),
        .trig_all   (trig_all),
        .clr_all    (clr_all),
        .bus_rdata  (bus_rdata)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        gpio_irq_port #(
            .NPINS (NPINS)
        ) u_port (
            .clk    (clk),
            .rst    (rst),
            .pins   (pin_in[g*NPINS +: NPINS]),
            .trig   (trig_all[g*NPINS +: NPINS]),
            .clr    (clr_all[g*NPINS +: NPINS]),
            .enable (enable_all[g*NPINS +: NPINS]),
            .status (status_all[g*NPINS +: NPINS]),
            .irq    (port_irq[g])
        );
    end

    assign bank_irq = |port_irq;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int NBITS = NPORTS * NPINS
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NBITS-1:0]      pin_in,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [NPORTS-1:0]     port_irq,
    input logic                  bank_irq,
    input logic [NBITS-1:0]      status_all,
    input logic [NBITS-1:0]      enable_all,
    input pin_trig_t [NBITS-1:0] trig_all,
    input logic [NBITS-1:0]      clr_all
);

    // Cycles since reset, saturating; gates looks into the past.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_irq == '0 && !bank_irq));

    assert_bank_from_pending_R10: assert property (@(posedge clk) disable iff (rst)
        bank_irq == |(status_all & enable_all));

    for (genvar i = 0; i < NBITS; i++) begin : g_pin
        // level modes (R5 and R6): pending mirrors the active level one cycle later
        assert_level_tracks_R5: assert property (@(posedge clk) disable iff (rst)
            (since_rst != 2'd0 && !trig_all[i].edge_sel)
            |=> status_all[i] == $past(pin_in[i] == trig_all[i].polarity));

        assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && trig_all[i].edge_sel && !status_all[i])
            |=> (!status_all[i] || $past(pin_in[i]) != $past(pin_in[i], 2)));

        assert_clear_edge_R7: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && trig_all[i].edge_sel && clr_all[i]
             && pin_in[i] == $past(pin_in[i]))
            |=> !status_all[i]);

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && trig_all[i].edge_sel && trig_all[i].both
             && pin_in[i] != $past(pin_in[i]))
            |=> status_all[i]);
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assert_masked_enable_keeps_R11: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADDR_W'(12'h850 + 4*g))
            |=> (((enable_all[g*NPINS +: NPINS] ^ $past(enable_all[g*NPINS +: NPINS]))
                  & ~$past(bus_wdata[NPINS +: NPINS])) == '0));
    end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .NPORTS (NPORTS),
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .port_irq   (port_irq),
    .bank_irq   (bank_irq),
    .status_all (status_all),
    .enable_all (enable_all),
    .trig_all   (trig_all),
    .clr_all    (clr_all)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    localparam int NPORTS = 4;
    localparam int NPINS  = 8;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [NPORTS*NPINS-1:0] pin_in;
    logic                    bus_we;
    logic [ADDR_W-1:0]       bus_addr;
    logic [DATA_W-1:0]       bus_wdata;
    logic [DATA_W-1:0]       bus_rdata;
    logic [NPORTS-1:0]       port_irq;
    logic                    bank_irq;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_bank #(
        .NPORTS (NPORTS),
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_irq  (port_irq),
        .bank_irq  (bank_irq)
    );

    typedef struct packed {
        logic [DATA_W-1:0] exp_data;
        logic              chk_irq;
        logic [NPORTS-1:0] exp_port;
        logic              exp_bank;
    } sb_item_t;

    sb_item_t sb_q[$];
    string    tag_q[$];
    int       checks   = 0;
    int       failures = 0;
    bit       done     = 1'b0;

    // Monitor: compares expected items just after the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                string    tg;
                it = sb_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp_data) begin
                    failures++;
                    $display("FAIL %s: rdata actual=%h expected=%h", tg, bus_rdata, it.exp_data);
                end else if (it.chk_irq && (port_irq !== it.exp_port || bank_irq !== it.exp_bank)) begin
                    failures++;
                    $display("FAIL %s: irq actual port=%b bank=%b expected port=%b bank=%b",
                             tg, port_irq, bank_irq, it.exp_port, it.exp_bank);
                end
            end
        end
    end

    // Driver tasks: each starts and ends on a falling edge.
    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic set_pins(input int port, input logic [NPINS-1:0] v);
        pin_in[port*NPINS +: NPINS] = v;
        @(negedge clk);
    endtask

    task automatic expect_reg(input string tg, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d, input logic ci,
                              input logic [NPORTS-1:0] ep, input logic eb);
        sb_item_t it;
        bus_addr    = a;
        it.exp_data = d;
        it.chk_irq  = ci;
        it.exp_port = ep;
        it.exp_bank = eb;
        sb_q.push_back(it);
        tag_q.push_back(tg);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        expect_reg("R1 port0 enable after reset", 12'h050, 32'h0, 1'b1, 4'b0000, 1'b0);
        expect_reg("R1 port3 enable after reset", 12'h05C, 32'h0, 1'b1, 4'b0000, 1'b0);
        expect_reg("R6 level-low pending with pins low", 12'h040, 32'hFF, 1'b0, '0, 1'b0);

        // rising on all pins of port 0
        reg_write(12'h060, 32'h0000_FFFF);
        reg_write(12'h070, 32'hFF);
        expect_reg("R7 clear all edge pending", 12'h040, 32'h0, 1'b0, '0, 1'b0);
        expect_reg("R13 trigger word readback", 12'h060, 32'h0000_FFFF, 1'b0, '0, 1'b0);
        set_pins(0, 8'h05);
        expect_reg("R2 rising edges captured", 12'h040, 32'h05, 1'b0, '0, 1'b0);
        set_pins(0, 8'h00);
        expect_reg("R2 falling ignored in rising mode", 12'h040, 32'h05, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'h01);
        expect_reg("R7 zero bits leave pending alone", 12'h040, 32'h04, 1'b0, '0, 1'b0);
        reg_write(12'h050, 32'h04);
        expect_reg("R10 irq from enabled pending pin", 12'h040, 32'h04, 1'b1, 4'b0001, 1'b1);
        reg_write(12'h070, 32'h04);
        expect_reg("R10 irq drops after clear", 12'h040, 32'h0, 1'b1, 4'b0000, 1'b0);

        // falling on pins 0..3 through the masked trigger alias
        reg_write(12'h860, 32'h0F00_0F00);
        expect_reg("R12 masked trigger update", 12'h060, 32'h0000_FFF0, 1'b0, '0, 1'b0);
        set_pins(0, 8'hFF);
        expect_reg("R3 rising ignored by falling pins", 12'h040, 32'hF0, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'hFF);
        set_pins(0, 8'h00);
        expect_reg("R3 falling edges captured", 12'h040, 32'h0F, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'hFF);

        // both edges
        reg_write(12'h060, 32'h00FF_FF00);
        set_pins(0, 8'h10);
        expect_reg("R4 both mode rising", 12'h040, 32'h10, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'hFF);
        set_pins(0, 8'h00);
        expect_reg("R4 both mode falling", 12'h040, 32'h10, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'hFF);

        // edge and clear in the same cycle
        pin_in[7:0] = 8'h02;
        reg_write(12'h070, 32'hFF);
        expect_reg("R8 set wins over same-cycle clear", 12'h040, 32'h02, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'h02);
        expect_reg("R9 pending cleared", 12'h040, 32'h0, 1'b0, '0, 1'b0);
        set_pins(0, 8'h00);
        expect_reg("R9 edge after clear sets again", 12'h040, 32'h02, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'hFF);

        // level high, then level low
        reg_write(12'h060, 32'h0000_00FF);
        set_pins(0, 8'h30);
        expect_reg("R5 level high follows pins", 12'h040, 32'h30, 1'b0, '0, 1'b0);
        reg_write(12'h070, 32'h30);
        expect_reg("R7 clear has no lasting effect on active level", 12'h040, 32'h30, 1'b0, '0, 1'b0);
        set_pins(0, 8'h00);
        expect_reg("R5 pending drops with level", 12'h040, 32'h0, 1'b0, '0, 1'b0);
        reg_write(12'h060, 32'h0);
        set_pins(0, 8'h0F);
        expect_reg("R6 level low follows inverted pins", 12'h040, 32'hF0, 1'b0, '0, 1'b0);

        // masked enable: select pins 0,1, set pin 0 only; pin 2 keeps 1
        reg_write(12'h850, 32'h0000_0301);
        expect_reg("R11 masked enable update", 12'h050, 32'h05, 1'b1, 4'b0000, 1'b0);

        // port 2 drives the bank line on its own
        reg_write(12'h068, 32'h0000_FFFF);
        reg_write(12'h078, 32'hFF);
        reg_write(12'h058, 32'h80);
        expect_reg("R10 port2 armed with nothing pending", 12'h048, 32'h0, 1'b1, 4'b0000, 1'b0);
        set_pins(2, 8'h80);
        expect_reg("R10 bank irq from port2", 12'h048, 32'h80, 1'b1, 4'b0100, 1'b1);
        expect_reg("R13 clear word reads zero", 12'h078, 32'h0, 1'b0, '0, 1'b0);
        expect_reg("R13 masked alias reads zero", 12'h850, 32'h0, 1'b0, '0, 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule